// File: doc/BRIEF.md
# Script Branch Condition Evaluator

This block carries out the flow-control step of a small script engine that drives a parallel peripheral bus. The fetch logic presents one decoded instruction as a 32-bit command/count word plus a 32-bit destination word, together with the current script pointer. The block decides whether the instruction's condition holds and then performs one of four actions: jump, call, return or raise a script interrupt.

The condition is built from two optional terms that are ANDed together. The first compares the latched first byte received against a literal, with a per-bit exclusion mask. The second compares the live bus phase against an expected phase. A polarity flag picks whether the branch is taken when the condition is true or when it is false. An optional wait flag makes the block stall until a REQ-valid strobe arrives. Both terms are then sampled in that same cycle.

The block produces the next script pointer. It also holds a single return slot, written by a taken call, and a sticky script-interrupt status bit. A done pulse marks the end of each instruction it accepts. Instruction fetch, the bus handshake itself and the other instruction classes belong to neighbouring logic.

Top module: `tc_branch_unit`

## Requirements
- R1: An instruction is accepted only when `start` is high, the block is idle, command bits 31:30 equal 2'b10 and bits 23:20 are zero. Any other command (type 00, 01 or 11, or nonzero bits 23:20) produces no `done` and leaves `new_ptr`, `ret_ptr` and `irq_status` unchanged.
- R2: Command bits 29:27 select the action: 000 jump, 001 call, 010 return, 011 interrupt. Codes 100 to 111 are ignored in the same way as in R1.
- R3: When bit 18 is set, the data term is true only if `first_byte` equals bits 7:0 in every position where mask bits 15:8 hold 0. A mask bit of 1 excludes that position from the compare.
- R4: When bit 17 is set, the phase term is true only if `bus_phase` equals command bits 26:24. The phase is ordered MSG, C/D, I/O from bit 2 down to bit 0. The codes are data-out 000, data-in 001, command 010, status 011, message-out 110 and message-in 111.
- R5: A disabled term counts as true, so with bits 18 and 17 both clear the condition is true. The branch is taken when the condition equals bit 19.
- R6: When bit 16 is set, the block stays busy and gives no `done` until `req_valid` is high. It evaluates with `first_byte` and `bus_phase` from that same cycle. A `start` that arrives while busy is ignored.
- R7: A taken jump loads `new_ptr` with the destination word.
- R8: A taken call writes the current pointer + 8 into `ret_ptr` and loads `new_ptr` with the destination word. No other action changes `ret_ptr`.
- R9: A taken return loads `new_ptr` from `ret_ptr`.
- R10: A taken interrupt sets `irq_status` bit 2 (value 0x04) and loads `new_ptr` with the current pointer + 8. The bit stays set until `status_clr` is high in a cycle where no new interrupt sets it.
- R11: An instruction that is not taken loads `new_ptr` with the current pointer + 8 and changes neither `ret_ptr` nor `irq_status`.
- R12: `done` is high for one cycle, in the cycle after the evaluation. `taken` and the updated `new_ptr` are valid from that cycle on.
- R13: After reset `done`, `busy`, `taken`, `new_ptr`, `ret_ptr` and `irq_status` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Instruction present for one cycle |
| cmd_word | input | 32 | Command byte (31:24) and count field (23:0) |
| dest_word | input | 32 | Branch destination address |
| cur_ptr | input | 32 | Address of the instruction being executed |
| first_byte | input | 8 | Latched first received byte |
| bus_phase | input | 3 | Live phase lines {MSG, C/D, I/O} |
| req_valid | input | 1 | REQ-valid strobe that ends a wait |
| status_clr | input | 1 | Clears the script-interrupt status bit |
| busy | output | 1 | Waiting for REQ-valid |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch outcome of the last instruction |
| new_ptr | output | 32 | Next script pointer |
| ret_ptr | output | 32 | Saved return address |
| irq_status | output | 8 | DMA-side status; bit 2 is the script interrupt |

## Verification
Two events can land on the same clock edge. One is the end of a wait, when `req_valid` arrives and the block evaluates its condition. The other is a fresh `start` from the fetch side. The bench raises `start` with a different, contradictory instruction while the block waits, and then again on the very cycle `req_valid` is high. It judges the outcome by checking that `new_ptr`, `taken` and `ret_ptr` reflect only the instruction that began the wait. It also checks that exactly one `done` appears, in the cycle after the strobe.

// File: rtl/tc_branch_pkg.sv
package tc_branch_pkg;

    // instruction class value in command bits 31:30
    localparam logic [1:0] CLASS_FLOW = 2'b10;

    typedef enum logic [1:0] {
        OP_JUMP   = 2'b00,
        OP_CALL   = 2'b01,
        OP_RETURN = 2'b10,
        OP_INT    = 2'b11
    } tc_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } tc_state_e;

    typedef struct packed {
        logic       legal;
        tc_op_e     op;
        logic [2:0] want_phase;
        logic       on_true;
        logic       use_data;
        logic       use_phase;
        logic       need_req;
        logic [7:0] skip_mask;
        logic [7:0] ref_byte;
    } tc_instr_t;

endpackage

// File: rtl/tc_decode.sv
module tc_decode
    import tc_branch_pkg::*;
(
    input  logic [31:0] cmd_word,
    output tc_instr_t   instr
);
    logic [1:0] cls;
    logic [2:0] opc;
    logic [3:0] rsvd;

    always_comb begin
        cls  = cmd_word[31:30];
        opc  = cmd_word[29:27];
        rsvd = cmd_word[23:20];
        instr.legal      = (cls == CLASS_FLOW) && (rsvd == 4'd0) && !opc[2];
        instr.op         = tc_op_e'(opc[1:0]);
        instr.want_phase = cmd_word[26:24];
        instr.on_true    = cmd_word[19];
        instr.use_data   = cmd_word[18];
        instr.use_phase  = cmd_word[17];
        instr.need_req   = cmd_word[16];
        instr.skip_mask  = cmd_word[15:8];
        instr.ref_byte   = cmd_word[7:0];
    end
endmodule

// File: rtl/tc_cond_eval.sv
module tc_cond_eval
    import tc_branch_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int PHASE_W = 3
) (
    input  tc_instr_t            instr,
    input  logic [BYTE_W-1:0]    first_byte,
    input  logic [PHASE_W-1:0]   bus_phase,
    output logic                 take
);
    logic [BYTE_W-1:0] diff;
    logic data_ok;
    logic phase_ok;
    logic cond;

    always_comb begin
        diff     = (first_byte ^ instr.ref_byte) & ~instr.skip_mask;
        data_ok  = !instr.use_data  || (diff == '0);
        phase_ok = !instr.use_phase || (bus_phase == instr.want_phase);
        cond     = data_ok && phase_ok;
        take     = (cond == instr.on_true);
    end
endmodule

// File: rtl/tc_branch_unit.sv
module tc_branch_unit
    import tc_branch_pkg::*;
#(
    parameter int PTR_W       = 32,
    parameter int INSTR_BYTES = 8,
    parameter int SIR_BIT     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       cmd_word,
    input  logic [PTR_W-1:0]  dest_word,
    input  logic [PTR_W-1:0]  cur_ptr,
    input  logic [7:0]        first_byte,
    input  logic [2:0]        bus_phase,
    input  logic              req_valid,
    input  logic              status_clr,
    output logic              busy,
    output logic              done,
    output logic              taken,
    output logic [PTR_W-1:0]  new_ptr,
    output logic [PTR_W-1:0]  ret_ptr,
    output logic [7:0]        irq_status
);
    localparam logic [PTR_W-1:0] STEP = PTR_W'(INSTR_BYTES);

    typedef struct packed {
        tc_state_e        st;
        tc_instr_t        ins;
        logic [PTR_W-1:0] dest;
        logic [PTR_W-1:0] base;
        logic [PTR_W-1:0] nptr;
        logic [PTR_W-1:0] ret;
        logic             sir;
        logic             done;
        logic             taken;
    } regs_t;

    regs_t q, d;

    tc_instr_t        live_ins;
    tc_instr_t        eval_ins;
    logic [PTR_W-1:0] eval_dest;
    logic [PTR_W-1:0] eval_base;
    logic             take;

    tc_decode u_dec (
        .cmd_word (cmd_word),
        .instr    (live_ins)
    );

    always_comb begin
        if (q.st == ST_WAIT) begin
            eval_ins  = q.ins;
            eval_dest = q.dest;
            eval_base = q.base;
        end else begin
            eval_ins  = live_ins;
            eval_dest = dest_word;
            eval_base = cur_ptr;
        end
    end

    tc_cond_eval #(.BYTE_W(8), .PHASE_W(3)) u_cond (
        .instr      (eval_ins),
        .first_byte (first_byte),
        .bus_phase  (bus_phase),
        .take       (take)
    );

    always_comb begin
        logic exec;
        logic set_sir;
        d       = q;
        d.done  = 1'b0;
        exec    = 1'b0;
        set_sir = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (start && live_ins.legal) begin
                    d.ins  = live_ins;
                    d.dest = dest_word;
                    d.base = cur_ptr;
                    if (live_ins.need_req) d.st = ST_WAIT;
                    else                   exec = 1'b1;
                end
            end
            ST_WAIT: begin
                if (req_valid) begin
                    exec = 1'b1;
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (exec) begin
            d.done  = 1'b1;
            d.taken = take;
            d.nptr  = eval_base + STEP;
            if (take) begin
                case (eval_ins.op)
                    OP_JUMP:   d.nptr = eval_dest;
                    OP_CALL: begin
                        d.ret  = eval_base + STEP;
                        d.nptr = eval_dest;
                    end
                    OP_RETURN: d.nptr = q.ret;
                    OP_INT:    set_sir = 1'b1;
                    default:   d.nptr = eval_base + STEP;
                endcase
            end
        end

        if (set_sir)         d.sir = 1'b1;
        else if (status_clr) d.sir = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        busy       = (q.st == ST_WAIT);
        done       = q.done;
        taken      = q.taken;
        new_ptr    = q.nptr;
        ret_ptr    = q.ret;
        irq_status = 8'(q.sir) << SIR_BIT;
    end
endmodule

// File: rtl/tc_branch_chk.sv
module tc_branch_chk #(
    parameter int PTR_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [31:0]      cmd_word,
    input logic             req_valid,
    input logic             busy,
    input logic             done,
    input logic             taken,
    input logic [PTR_W-1:0] new_ptr,
    input logic [PTR_W-1:0] ret_ptr,
    input logic [7:0]       irq_status
);
    // R1: wrong class leaves outputs alone
    p_class_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cmd_word[31:30] != 2'b10)
        |=> (!done && $stable(new_ptr) && $stable(ret_ptr)));

    // R6: no completion while still waiting for the strobe
    p_hold_for_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !req_valid) |=> !done);

    // R8: return slot moves only on a taken completion
    p_ret_on_call_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ret_ptr) |-> (done && taken));

    // R10: interrupt bit rises only with a taken completion
    p_sir_on_int_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status[2]) |-> (done && taken));

    // R12: completion leaves the block idle
    p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind tc_branch_unit tc_branch_chk #(.PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cmd_word   (cmd_word),
    .req_valid  (req_valid),
    .busy       (busy),
    .done       (done),
    .taken      (taken),
    .new_ptr    (new_ptr),
    .ret_ptr    (ret_ptr),
    .irq_status (irq_status)
);

// File: tb/tc_branch_unit_test.sv
module tc_branch_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [31:0] dest_word = '0;
    logic [31:0] cur_ptr = '0;
    logic [7:0]  first_byte = '0;
    logic [2:0]  bus_phase = '0;
    logic        req_valid = 1'b0;
    logic        status_clr = 1'b0;
    logic        busy, done, taken;
    logic [31:0] new_ptr, ret_ptr;
    logic [7:0]  irq_status;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    tc_branch_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_word(cmd_word),
        .dest_word(dest_word), .cur_ptr(cur_ptr), .first_byte(first_byte),
        .bus_phase(bus_phase), .req_valid(req_valid), .status_clr(status_clr),
        .busy(busy), .done(done), .taken(taken), .new_ptr(new_ptr),
        .ret_ptr(ret_ptr), .irq_status(irq_status)
    );

    function automatic logic [31:0] mk(input logic [1:0] cls, input logic [2:0] op,
                                       input logic [2:0] ph, input logic t,
                                       input logic cd, input logic cp, input logic w,
                                       input logic [7:0] msk, input logic [7:0] dat);
        return {cls, op, ph, 4'b0000, t, cd, cp, w, msk, dat};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one instruction at a falling edge; return at the next falling edge
    task automatic issue(input logic [31:0] c, input logic [31:0] dst, input logic [31:0] p);
        cmd_word = c; dest_word = dst; cur_ptr = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset;
        chk("R13 done", 32'(done), 0);
        chk("R13 busy", 32'(busy), 0);
        chk("R13 taken", 32'(taken), 0);
        chk("R13 new_ptr", new_ptr, 0);
        chk("R13 ret_ptr", ret_ptr, 0);
        chk("R13 irq_status", 32'(irq_status), 0);
    endtask

    task automatic t_jump;
        issue(mk(2'b10, 3'b000, 3'b000, 1, 0, 0, 0, 8'h00, 8'h00), 32'h0000_0400, 32'h0000_0020);
        chk("R12 done pulse", 32'(done), 1);
        chk("R7 jump target", new_ptr, 32'h400);
        chk("R5 no-compare true", 32'(taken), 1);
        @(negedge clk);
        chk("R12 done one cycle", 32'(done), 0);
        issue(mk(2'b10, 3'b000, 3'b000, 0, 0, 0, 0, 8'h00, 8'h00), 32'h0000_0400, 32'h0000_0040);
        chk("R5 false polarity no compare", 32'(taken), 0);
        chk("R11 fallthrough", new_ptr, 32'h48);
    endtask

    task automatic t_data;
        first_byte = 8'hA3;
        issue(mk(2'b10, 3'b000, 3'b000, 1, 1, 0, 0, 8'h0F, 8'hA5), 32'h0000_0800, 32'h0000_0100);
        chk("R3 masked match taken", 32'(taken), 1);
        chk("R3 masked match ptr", new_ptr, 32'h800);
        first_byte = 8'hB5;
        issue(mk(2'b10, 3'b000, 3'b000, 1, 1, 0, 0, 8'h0F, 8'hA5), 32'h0000_0800, 32'h0000_0100);
        chk("R3 unmasked mismatch", 32'(taken), 0);
        chk("R11 mismatch ptr", new_ptr, 32'h108);
    endtask

    task automatic t_phase;
        bus_phase = 3'b111;
        issue(mk(2'b10, 3'b000, 3'b111, 1, 0, 1, 0, 8'h00, 8'h00), 32'h0000_0C00, 32'h0000_0200);
        chk("R4 msg-in match", new_ptr, 32'hC00);
        bus_phase = 3'b110;
        issue(mk(2'b10, 3'b000, 3'b111, 1, 0, 1, 0, 8'h00, 8'h00), 32'h0000_0C00, 32'h0000_0200);
        chk("R4 msg-out vs msg-in", 32'(taken), 0);
        issue(mk(2'b10, 3'b000, 3'b111, 0, 0, 1, 0, 8'h00, 8'h00), 32'h0000_0D00, 32'h0000_0200);
        chk("R5 jump-if-false on mismatch", new_ptr, 32'hD00);
        // both terms: phase matches, data mismatches
        bus_phase = 3'b011; first_byte = 8'h01;
        issue(mk(2'b10, 3'b000, 3'b011, 1, 1, 1, 0, 8'h00, 8'h02), 32'h0000_0E00, 32'h0000_0300);
        chk("R3 R4 and of terms", 32'(taken), 0);
    endtask

    task automatic t_call_ret;
        issue(mk(2'b10, 3'b001, 3'b000, 1, 0, 0, 0, 8'h00, 8'h00), 32'h0000_1000, 32'h0000_0100);
        chk("R8 call ret", ret_ptr, 32'h108);
        chk("R8 call target", new_ptr, 32'h1000);
        issue(mk(2'b10, 3'b001, 3'b000, 0, 0, 0, 0, 8'h00, 8'h00), 32'h0000_2000, 32'h0000_1000);
        chk("R11 untaken call keeps ret", ret_ptr, 32'h108);
        issue(mk(2'b10, 3'b010, 3'b000, 1, 0, 0, 0, 8'h00, 8'h00), 32'h0000_3000, 32'h0000_1008);
        chk("R9 return", new_ptr, 32'h108);
    endtask

    task automatic t_int;
        issue(mk(2'b10, 3'b011, 3'b000, 1, 0, 0, 0, 8'h00, 8'h00), 32'h0000_5000, 32'h0000_0500);
        chk("R10 status bit", 32'(irq_status), 32'h04);
        chk("R10 int ptr", new_ptr, 32'h508);
        @(negedge clk);
        chk("R10 sticky", 32'(irq_status), 32'h04);
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
        chk("R10 cleared", 32'(irq_status), 32'h00);
        issue(mk(2'b10, 3'b011, 3'b000, 0, 0, 0, 0, 8'h00, 8'h00), 32'h0000_5000, 32'h0000_0500);
        chk("R11 untaken int no status", 32'(irq_status), 32'h00);
    endtask

    task automatic t_ignore;
        logic [31:0] keep_ptr, keep_ret;
        keep_ptr = new_ptr; keep_ret = ret_ptr;
        issue(mk(2'b01, 3'b000, 3'b000, 1, 0, 0, 0, 8'h00, 8'h00), 32'h0000_7000, 32'h0000_0700);
        chk("R1 class 01 no done", 32'(done), 0);
        issue(mk(2'b11, 3'b001, 3'b000, 1, 0, 0, 0, 8'h00, 8'h00), 32'h0000_7000, 32'h0000_0700);
        chk("R1 class 11 no done", 32'(done), 0);
        issue(mk(2'b00, 3'b000, 3'b000, 1, 0, 0, 0, 8'h00, 8'h00), 32'h0000_7000, 32'h0000_0700);
        chk("R1 class 00 no done", 32'(done), 0);
        issue(mk(2'b10, 3'b000, 3'b000, 1, 0, 0, 0, 8'h00, 8'h00) | 32'h0010_0000,
              32'h0000_7000, 32'h0000_0700);
        chk("R1 reserved bits no done", 32'(done), 0);
        issue(mk(2'b10, 3'b100, 3'b000, 1, 0, 0, 0, 8'h00, 8'h00), 32'h0000_7000, 32'h0000_0700);
        chk("R2 op 100 no done", 32'(done), 0);
        issue(mk(2'b10, 3'b111, 3'b000, 1, 0, 0, 0, 8'h00, 8'h00), 32'h0000_7000, 32'h0000_0700);
        chk("R2 op 111 no done", 32'(done), 0);
        chk("R1 ptr unchanged", new_ptr, keep_ptr);
        chk("R1 ret unchanged", ret_ptr, keep_ret);
        chk("R1 status unchanged", 32'(irq_status), 0);
    endtask

    task automatic t_wait;
        bus_phase = 3'b000; first_byte = 8'h00;
        // call if phase == status, wait for REQ first
        issue(mk(2'b10, 3'b001, 3'b011, 1, 0, 1, 1, 8'h00, 8'h00), 32'h0000_9000, 32'h0000_0900);
        chk("R6 busy", 32'(busy), 1);
        chk("R6 no early done", 32'(done), 0);
        // conflicting start while busy
        issue(mk(2'b10, 3'b000, 3'b000, 1, 0, 0, 0, 8'h00, 8'h00), 32'h0000_AAA0, 32'h0000_0AA0);
        chk("R6 start ignored while busy", 32'(done), 0);
        chk("R6 still busy", 32'(busy), 1);
        bus_phase = 3'b011;
        req_valid = 1'b1;
        // another start coincides with the strobe
        issue(mk(2'b10, 3'b000, 3'b000, 1, 0, 0, 0, 8'h00, 8'h00), 32'h0000_BBB0, 32'h0000_0BB0);
        req_valid = 1'b0;
        chk("R6 done after strobe", 32'(done), 1);
        chk("R6 phase sampled at strobe", 32'(taken), 1);
        chk("R8 waited call target", new_ptr, 32'h9000);
        chk("R8 waited call ret", ret_ptr, 32'h908);
        @(negedge clk);
        chk("R12 single done", 32'(done), 0);
        chk("R6 idle after", 32'(busy), 0);
        chk("R6 coincident start dropped", new_ptr, 32'h9000);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_jump;
        t_data;
        t_phase;
        t_call_ret;
        t_int;
        t_ignore;
        t_wait;
        repeat (2) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule